// File: doc/BRIEF.md
# Fast-Lock Pump Switching Timer

This block governs the short high-bandwidth phase of a charge-pump PLL. When the fast-lock feature is enabled, a trigger starts a one-shot timer. A trigger is either a committed change of the divider setting or the PLL power pin going from low to high. While the timer runs, the block closes the loop-filter bypass switch and selects the high-current fast pump instead of the normal pump.

The timer counts phase-detector cycles, which arrive as a one-clock tick, and not system clocks. After the programmed number of ticks the switch opens and the normal pump takes over. A new trigger during the period restarts the count. Clearing the enable bit ends the period at once.

The block also drives the pump driver controls:
- the current step for the selected pump, in units;
- the up/down pulses, with an optional polarity swap;
- a high-impedance control that forces every pump output off.

Top module: `fastlock_pump_ctrl`

## Requirements
- R1: While `fast_en_i` is 0, no trigger starts a period and `filt_sw_o` stays 0.
- R2: With `fast_en_i` at 1 and a nonzero `fast_cnt_i`, either of two events is a trigger. One is a `freq_commit_i` pulse. The other is `pll_pin_i` sampled low at one clock edge and high at the next. A trigger makes `filt_sw_o` 1 after the clock edge that samples it.
- R3: While a period is active, `filt_sw_o` is 1. Unless the pumps are tri-stated, `fast_pump_on_o` is also 1 and `norm_pump_on_o` is 0.
- R4: A period lasts for exactly N `pd_tick_i` ticks sampled after the trigger edge, where N is the loaded count. `filt_sw_o` falls after the edge that samples the Nth tick. A tick in the trigger cycle is not counted.
- R5: Outside a period and when not tri-stated, `norm_pump_on_o` is 1 and `fast_pump_on_o` is 0.
- R6: A trigger seen while `fast_cnt_i` is 0 leaves the timer state unchanged.
- R7: A trigger during an active period reloads the count from the present `fast_cnt_i`.
- R8: Clearing `fast_en_i` drops `filt_sw_o` and selects the normal pump in the same cycle, with no clock edge needed. The period stays ended when the enable returns.
- R9: `pump_units_o` is the normal code plus 1 when the normal pump is on. It is the fast code plus 4 when the fast pump is on.
- R10: When `cp_hiz_i` is 1 or `pll_pin_i` is 0, `pump_hiz_o` is 1. Both pump enables, both up/down outputs and `pump_units_o` are then 0. The timer and `filt_sw_o` are not affected.
- R11: With `cp_pol_i` at 0, `pump_up_o` follows `pfd_up_i` and `pump_dn_o` follows `pfd_dn_i`. With `cp_pol_i` at 1 the two are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_tick_i | input | 1 | One-clock pulse per phase-detector cycle |
| freq_commit_i | input | 1 | Pulse when a new divider setting is committed |
| pll_pin_i | input | 1 | PLL power pin, 1 = running |
| fast_en_i | input | 1 | Fast-lock feature enable |
| fast_cnt_i | input | CNT_W (13) | Fast period length in phase-detector cycles |
| norm_code_i | input | NCODE_W (4) | Normal pump current code |
| fast_code_i | input | FCODE_W (3) | Fast pump current code |
| cp_hiz_i | input | 1 | Force pump outputs to high impedance |
| cp_pol_i | input | 1 | Swap up/down sense |
| pfd_up_i | input | 1 | Phase detector up request |
| pfd_dn_i | input | 1 | Phase detector down request |
| filt_sw_o | output | 1 | Loop-filter bypass switch closed |
| fast_pump_on_o | output | 1 | Fast pump enabled |
| norm_pump_on_o | output | 1 | Normal pump enabled |
| pump_hiz_o | output | 1 | Pump outputs tri-stated |
| pump_units_o | output | UNIT_W (5) | Current of the active pump, in units |
| pump_up_o | output | 1 | Up pulse to the active pump |
| pump_dn_o | output | 1 | Down pulse to the active pump |

## Verification
The hardest case to reach is a trigger that lands in the same cycle as a phase-detector tick near the end of a period. A nearby variant is an enable drop between two ticks. Either one must end or reload the period exactly on the right edge.

Directed sequences build these cases with short counts. A long random run then uses counts of 1 to 8 and frequent ticks, commits, pin toggles and enable drops. Expiry, reload and cancellation therefore occur many times in arbitrary orders. Every cycle is compared against a reference timer kept by the bench.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int NORM_UNIT_OFS = 1;
  localparam int FAST_UNIT_OFS = 4;

  typedef enum logic [1:0] {
    PUMP_OFF  = 2'd0,
    PUMP_NORM = 2'd1,
    PUMP_FAST = 2'd2
  } pump_sel_e;
endpackage

// File: rtl/fl_trigger.sv
module fl_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freq_commit_i,
  input  logic pll_pin_i,
  output logic trig_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pll_pin_i;
  end

  // power pin release counts as a start
  assign trig_o = freq_commit_i | (pll_pin_i & ~pin_q);
endmodule

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             active_o
);
  logic [CNT_W-1:0] rem_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (!en_i) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (trig_i) begin
      // zero count is illegal: ignore the trigger
      if (load_i != '0) begin
        act_q <= 1'b1;
        rem_q <= load_i;
      end
    end else if (act_q && tick_i) begin
      if (rem_q == CNT_W'(1)) act_q <= 1'b0;
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/fl_pump_drv.sv
module fl_pump_drv
  import fl_pkg::*;
#(
  parameter int NCODE_W = 4,
  parameter int FCODE_W = 3,
  parameter int UNIT_W  = 5
) (
  input  logic               fast_i,
  input  logic               hiz_i,
  input  logic               pol_i,
  input  logic               up_i,
  input  logic               dn_i,
  input  logic [NCODE_W-1:0] norm_code_i,
  input  logic [FCODE_W-1:0] fast_code_i,
  output logic               fast_on_o,
  output logic               norm_on_o,
  output logic [UNIT_W-1:0]  units_o,
  output logic               up_o,
  output logic               dn_o
);
  pump_sel_e sel;

  always_comb begin
    if (hiz_i)       sel = PUMP_OFF;
    else if (fast_i) sel = PUMP_FAST;
    else             sel = PUMP_NORM;
  end

  always_comb begin
    fast_on_o = 1'b0;
    norm_on_o = 1'b0;
    units_o   = '0;
    up_o      = 1'b0;
    dn_o      = 1'b0;
    unique case (sel)
      PUMP_FAST: begin
        fast_on_o = 1'b1;
        units_o   = UNIT_W'(fast_code_i) + UNIT_W'(FAST_UNIT_OFS);
      end
      PUMP_NORM: begin
        norm_on_o = 1'b1;
        units_o   = UNIT_W'(norm_code_i) + UNIT_W'(NORM_UNIT_OFS);
      end
      default: ;
    endcase
    if (sel != PUMP_OFF) begin
      up_o = pol_i ? dn_i : up_i;
      dn_o = pol_i ? up_i : dn_i;
    end
  end
endmodule

// File: rtl/fastlock_pump_ctrl.sv
module fastlock_pump_ctrl #(
  parameter int CNT_W   = 13,
  parameter int NCODE_W = 4,
  parameter int FCODE_W = 3,
  parameter int UNIT_W  = $clog2((((1 << NCODE_W) > ((1 << FCODE_W) + 3)) ?
                                  (1 << NCODE_W) : ((1 << FCODE_W) + 3)) + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pd_tick_i,
  input  logic               freq_commit_i,
  input  logic               pll_pin_i,
  input  logic               fast_en_i,
  input  logic [CNT_W-1:0]   fast_cnt_i,
  input  logic [NCODE_W-1:0] norm_code_i,
  input  logic [FCODE_W-1:0] fast_code_i,
  input  logic               cp_hiz_i,
  input  logic               cp_pol_i,
  input  logic               pfd_up_i,
  input  logic               pfd_dn_i,
  output logic               filt_sw_o,
  output logic               fast_pump_on_o,
  output logic               norm_pump_on_o,
  output logic               pump_hiz_o,
  output logic [UNIT_W-1:0]  pump_units_o,
  output logic               pump_up_o,
  output logic               pump_dn_o
);
  logic trig;
  logic active;
  logic fast_phase;

  fl_trigger u_trig (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .freq_commit_i(freq_commit_i),
    .pll_pin_i    (pll_pin_i),
    .trig_o       (trig)
  );

  fl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (fast_en_i),
    .trig_i  (trig),
    .tick_i  (pd_tick_i),
    .load_i  (fast_cnt_i),
    .active_o(active)
  );

  // enable gates combinationally so a clear takes effect at once
  assign fast_phase = active & fast_en_i;
  assign filt_sw_o  = fast_phase;
  assign pump_hiz_o = cp_hiz_i | ~pll_pin_i;

  fl_pump_drv #(
    .NCODE_W(NCODE_W),
    .FCODE_W(FCODE_W),
    .UNIT_W (UNIT_W)
  ) u_drv (
    .fast_i     (fast_phase),
    .hiz_i      (pump_hiz_o),
    .pol_i      (cp_pol_i),
    .up_i       (pfd_up_i),
    .dn_i       (pfd_dn_i),
    .norm_code_i(norm_code_i),
    .fast_code_i(fast_code_i),
    .fast_on_o  (fast_pump_on_o),
    .norm_on_o  (norm_pump_on_o),
    .units_o    (pump_units_o),
    .up_o       (pump_up_o),
    .dn_o       (pump_dn_o)
  );
endmodule

// File: rtl/fastlock_pump_ctrl_chk.sv
module fastlock_pump_ctrl_chk #(
  parameter int CNT_W  = 13,
  parameter int UNIT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pd_tick_i,
  input logic              freq_commit_i,
  input logic              fast_en_i,
  input logic [CNT_W-1:0]  fast_cnt_i,
  input logic              cp_pol_i,
  input logic              pfd_up_i,
  input logic              pfd_dn_i,
  input logic              filt_sw_o,
  input logic              fast_pump_on_o,
  input logic              norm_pump_on_o,
  input logic              pump_hiz_o,
  input logic [UNIT_W-1:0] pump_units_o,
  input logic              pump_up_o,
  input logic              pump_dn_o
);
  a_r1_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_en_i |-> !filt_sw_o);

  a_r2_commit_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_en_i && freq_commit_i && fast_cnt_i != '0) |=> (filt_sw_o || !fast_en_i));

  a_r3_one_pump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fast_pump_on_o && norm_pump_on_o));

  a_r4_no_end_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_sw_o && !pd_tick_i) |=> (filt_sw_o || !fast_en_i));

  a_r9_fast_units_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_pump_on_o |-> (pump_units_o >= UNIT_W'(4)));

  a_r10_hiz_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_hiz_o |-> (!fast_pump_on_o && !norm_pump_on_o && !pump_up_o &&
                    !pump_dn_o && pump_units_o == '0));

  a_r11_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pump_hiz_o && cp_pol_i) |-> (pump_up_o == pfd_dn_i && pump_dn_o == pfd_up_i));
endmodule

bind fastlock_pump_ctrl fastlock_pump_ctrl_chk #(.CNT_W(CNT_W), .UNIT_W(UNIT_W)) chk_i (.*);

// File: tb/fastlock_pump_ctrl_tb_top.sv
module fastlock_pump_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        tick, commit, pin, en, hiz, pol, up, dn;
  logic [12:0] cnt;
  logic [3:0]  ncode;
  logic [2:0]  fcode;
  logic        filt_sw, fast_on, norm_on, hiz_o, up_o, dn_o;
  logic [4:0]  units;

  fastlock_pump_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pd_tick_i(tick), .freq_commit_i(commit),
    .pll_pin_i(pin), .fast_en_i(en), .fast_cnt_i(cnt), .norm_code_i(ncode),
    .fast_code_i(fcode), .cp_hiz_i(hiz), .cp_pol_i(pol), .pfd_up_i(up),
    .pfd_dn_i(dn), .filt_sw_o(filt_sw), .fast_pump_on_o(fast_on),
    .norm_pump_on_o(norm_on), .pump_hiz_o(hiz_o), .pump_units_o(units),
    .pump_up_o(up_o), .pump_dn_o(dn_o)
  );

  int n_run = 0, n_fail = 0;
  int m_act = 0, m_rem = 0, m_pin_q = 0;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference timer, advanced once per clock edge from the sampled inputs
  task automatic model_step();
    if (!en) begin
      m_act = 0; m_rem = 0;
    end else if (commit || (pin && m_pin_q == 0)) begin
      if (cnt != 0) begin m_act = 1; m_rem = int'(cnt); end
    end else if (m_act == 1 && tick) begin
      if (m_rem == 1) m_act = 0;
      m_rem--;
    end
    m_pin_q = int'(pin);
  endtask

  function automatic int exp_units(int f, int h);
    if (h != 0) return 0;
    return (f != 0) ? int'(fcode) + 4 : int'(ncode) + 1;
  endfunction

  task automatic check_out();
    int f = (m_act == 1 && en) ? 1 : 0;
    int h = (hiz || !pin) ? 1 : 0;
    chk("R3/R8 filt_sw", int'(filt_sw), f);
    chk("R10 hiz", int'(hiz_o), h);
    chk("R3 fast_on", int'(fast_on), (f == 1 && h == 0) ? 1 : 0);
    chk("R5 norm_on", int'(norm_on), (f == 0 && h == 0) ? 1 : 0);
    chk("R9 units", int'(units), exp_units(f, h));
    chk("R11 up", int'(up_o), h ? 0 : int'(pol ? dn : up));
    chk("R11 dn", int'(dn_o), h ? 0 : int'(pol ? up : dn));
  endtask

  task automatic step();
    @(posedge clk);
    #1 model_step();
    #4 check_out();
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) begin
      tick = 1; step(); tick = 0; step();
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_f10c));
    {tick, commit, pin, en, hiz, pol, up, dn} = '0;
    cnt = 13'd3; ncode = 4'd9; fcode = 3'd5;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    #2;
    // reset state: pin low -> tri-stated, switch open
    chk("R10 reset hiz", int'(hiz_o), 1);
    chk("R1 reset filt_sw", int'(filt_sw), 0);
    step();

    // R1: triggers ignored while disabled
    pin = 1; commit = 1; step(); commit = 0; step();
    chk("R1 no start when disabled", int'(filt_sw), 0);
    chk("R5 normal pump units", int'(units), 10);
    pin = 0; step();

    // R2 + R4: pin release starts a 3-tick period
    en = 1; pin = 1; step();
    chk("R2 pin rise starts", int'(filt_sw), 1);
    chk("R9 fast units", int'(units), 9);
    ticks(2);
    chk("R4 still active after 2 of 3", int'(filt_sw), 1);
    tick = 1; step(); tick = 0;
    chk("R4 ends after 3rd tick", int'(filt_sw), 0);
    chk("R5 normal pump back", int'(norm_on), 1);

    // R7: retrigger reloads from the new count
    cnt = 13'd5; commit = 1; step(); commit = 0;
    ticks(2);
    cnt = 13'd2; commit = 1; tick = 1; step(); commit = 0; tick = 0;
    ticks(1);
    chk("R7 reloaded, active after 1 of 2", int'(filt_sw), 1);
    ticks(1);
    chk("R7 reloaded count expires", int'(filt_sw), 0);

    // R6: zero count ignored
    cnt = 13'd0; commit = 1; step(); commit = 0; step();
    chk("R6 zero count no start", int'(filt_sw), 0);

    // R8: enable clear ends at once
    cnt = 13'd6; commit = 1; step(); commit = 0;
    chk("R8 started", int'(filt_sw), 1);
    #2 en = 0; #1;
    chk("R8 immediate drop", int'(filt_sw), 0);
    chk("R8 normal pump", int'(norm_on), 1);
    step(); en = 1; step();
    chk("R8 stays off on re-enable", int'(filt_sw), 0);

    // R10: tri-state while active keeps timer
    commit = 1; step(); commit = 0; hiz = 1; up = 1; step();
    chk("R10 switch kept", int'(filt_sw), 1);
    chk("R10 pumps off", int'(fast_on) + int'(norm_on) + int'(up_o), 0);
    hiz = 0;

    // R11: polarity swap
    pol = 1; up = 1; dn = 0; step();
    chk("R11 swapped dn", int'(dn_o), 1);
    chk("R11 swapped up", int'(up_o), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick   = ($urandom_range(0, 2) == 0);
      commit = ($urandom_range(0, 14) == 0);
      if ($urandom_range(0, 40) == 0) pin = ~pin;
      if ($urandom_range(0, 30) == 0) en = ~en;
      hiz   = ($urandom_range(0, 9) == 0);
      pol   = 1'($urandom_range(0, 1));
      up    = 1'($urandom_range(0, 1));
      dn    = 1'($urandom_range(0, 1));
      cnt   = ($urandom_range(0, 20) == 0) ? 13'd0 : 13'($urandom_range(1, 8));
      ncode = 4'($urandom_range(0, 15));
      fcode = 3'($urandom_range(0, 7));
      step();
    end

    summary();
    $finish;
  end
endmodule